// File: doc/BRIEF.md
# Byte-Stuffed Frame Stream Decoder

This block sits behind a byte receiver and undoes Consistent Overhead Byte Stuffing on the fly. It takes one received byte per valid strobe and an overrun flag. For each payload byte it emits one decoded byte together with that byte's position in the frame. When a zero byte arrives it marks the end of a frame and reports how many decoded bytes the frame held. Storage of the decoded bytes and any meaning of the frame contents belong to the logic downstream.

The zero byte is the only delimiter. In an encoded frame, the first non-zero byte after a delimiter is the overhead byte, which gives the distance to the first hidden zero. Each later non-zero byte counts that distance down. The byte on which the distance runs out stands for a zero in the decoded data and gives the next distance. After reset, after an overrun, and after a frame that grows past its size limit, the decoder discards non-zero bytes until it sees a zero. It then starts clean on the next frame.

Top module: `cobs_rx_decoder`

## Requirements
- R1: After reset the decoder is in its sync-search state, `out_valid` and `frame_done` are low and `overrun_count` is zero.
- R2: While searching for sync, a non-zero input byte produces no output byte and no frame-done pulse.
- R3: A valid input byte equal to 0x00, with no overrun in the same cycle and in any state, raises `frame_done` for exactly one cycle on the next cycle. `frame_len` then equals the number of decoded bytes emitted since the previous delimiter or error. The write index returns to zero and the decoder waits for an overhead byte.
- R4: The first non-zero byte after a delimiter is the overhead byte. It loads the skip distance and produces no output byte.
- R5: A later non-zero byte on which the remaining distance does not run out appears unchanged on `out_byte` one cycle after it is accepted, with `out_valid` high.
- R6: A non-zero payload byte that arrives when the remaining distance is 1 is emitted as 0x00 and becomes the new distance.
- R7: `in_overrun` high on a clock edge resets the write index and returns the decoder to sync search. It takes precedence over any byte presented in the same cycle, so that byte produces no output and no frame-done pulse.
- R8: `overrun_count` goes up by one for each cycle in which `in_overrun` is high. It holds at its all-ones value.
- R9: A frame carries at most `MAX_PAYLOAD` decoded bytes. A further payload byte is dropped without output and sends the decoder back to sync search with the index cleared. A frame of exactly `MAX_PAYLOAD` bytes is reported in full.
- R10: Within a frame, `out_index` takes the values 0, 1, 2, ... on successive decoded bytes, and `out_valid` and `frame_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Received encoded byte |
| in_overrun | input | 1 | Receiver overrun seen this cycle |
| out_valid | output | 1 | A decoded byte is present on `out_byte` |
| out_byte | output | 8 | Decoded payload byte |
| out_index | output | IDX_W | Position of `out_byte` within its frame |
| frame_done | output | 1 | One-cycle pulse on frame delimiter |
| frame_len | output | IDX_W | Decoded byte count of the frame just closed |
| overrun_count | output | CNT_W | Saturating count of overrun cycles |

## Verification
The bench builds the decoder with `MAX_PAYLOAD` = 6 and `CNT_W` = 3. This brings the frame-size limit and the counter's saturation point within a few dozen cycles. With these values the bench can test a frame of exactly six bytes, a seven-byte overflow, and a counter that stops at 7. A behavioural model then follows a long stream of mixed random bytes, delimiters, small skip distances and overruns. It is compared with the decoder on every cycle.

// File: rtl/cobs_rx_pkg.sv
package cobs_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_HDR  = 2'd1,
    ST_RUN  = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] next_skip;
    logic [BYTE_W-1:0] data;
  } step_t;

  // One payload step: when the remaining distance is 1, this byte
  // stands for a hidden zero and carries the next distance.
  function automatic step_t cobs_step(input logic [BYTE_W-1:0] skip,
                                      input logic [BYTE_W-1:0] b);
    step_t r;
    if (skip == BYTE_W'(1)) begin
      r.next_skip = b;
      r.data      = '0;
    end else begin
      r.next_skip = skip - BYTE_W'(1);
      r.data      = b;
    end
    return r;
  endfunction

endpackage

// File: rtl/cobs_rx_fsm.sv
module cobs_rx_fsm
  import cobs_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_err,
  input  logic      ev_delim,
  input  logic      ev_hdr,
  input  logic      ev_overlong,
  output rx_state_e state_o
);

  rx_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SYNC;
    end else if (ev_err || ev_overlong) begin
      state_q <= ST_SYNC;
    end else if (ev_delim) begin
      state_q <= ST_HDR;
    end else if (ev_hdr) begin
      state_q <= ST_RUN;
    end
  end

  assign state_o = state_q;

  // R7
  err_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> state_q == ST_SYNC);

  // R3
  delim_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_delim && !ev_err) |=> state_q == ST_HDR);

endmodule

// File: rtl/cobs_rx_skip.sv
module cobs_rx_skip
  import cobs_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hdr,
  input  logic              ev_payload,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              zero_emit_o
);

  logic [BYTE_W-1:0] skip_q;
  step_t             step;

  assign step        = cobs_step(skip_q, byte_i);
  assign zero_emit_o = ev_payload && (skip_q == BYTE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q      <= '0;
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (ev_hdr) begin
        skip_q <= byte_i;
      end else if (ev_payload) begin
        skip_q      <= step.next_skip;
        out_byte_o  <= step.data;
        out_valid_o <= 1'b1;
      end
    end
  end

  // R6
  zero_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_emit_o |=> (out_valid_o && out_byte_o == '0));

  // R4
  hdr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |=> !out_valid_o);

  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_payload && !zero_emit_o) |=> (out_valid_o && out_byte_o == $past(byte_i)));

endmodule

// File: rtl/cobs_rx_index.sv
module cobs_rx_index #(
  parameter int MAX_PAYLOAD = 254,
  parameter int IDX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_err,
  input  logic             ev_delim,
  input  logic             ev_payload,
  input  logic             ev_overlong,
  output logic             full_o,
  output logic [IDX_W-1:0] out_index_o,
  output logic             frame_done_o,
  output logic [IDX_W-1:0] frame_len_o
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_PAYLOAD);

  logic [IDX_W-1:0] idx_q;

  assign full_o = (idx_q == MAX_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q        <= '0;
      out_index_o  <= '0;
      frame_done_o <= 1'b0;
      frame_len_o  <= '0;
    end else begin
      frame_done_o <= 1'b0;
      if (ev_err || ev_overlong) begin
        idx_q <= '0;
      end else if (ev_delim) begin
        frame_done_o <= 1'b1;
        frame_len_o  <= idx_q;
        idx_q        <= '0;
      end else if (ev_payload) begin
        out_index_o <= idx_q;
        idx_q       <= idx_q + IDX_W'(1);
      end
    end
  end

  // R9
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> frame_len_o <= MAX_IDX);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (!frame_done_o || $past(ev_delim)));

endmodule

// File: rtl/cobs_rx_satcnt.sv
module cobs_rx_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (inc_i && count_o != CNT_MAX) begin
      count_o <= count_o + CNT_W'(1);
    end
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX) |=> count_o == CNT_MAX);

  // R8
  sat_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && count_o != CNT_MAX) |=> count_o == $past(count_o) + CNT_W'(1));

endmodule

// File: rtl/cobs_rx_decoder.sv
module cobs_rx_decoder
  import cobs_rx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 254,
  parameter int CNT_W       = 16,
  localparam int IDX_W      = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_overrun,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [IDX_W-1:0]  out_index,
  output logic              frame_done,
  output logic [IDX_W-1:0]  frame_len,
  output logic [CNT_W-1:0]  overrun_count
);

  rx_state_e state;
  logic      byte_ok, is_zero, idx_full, zero_emit;
  logic      ev_err, ev_delim, ev_hdr, ev_payload, ev_overlong, ev_data;

  // Event decode: overrun wins over any byte in the same cycle.
  assign ev_err      = in_overrun;
  assign byte_ok     = in_valid && !in_overrun;
  assign is_zero     = (in_byte == '0);
  assign ev_delim    = byte_ok && is_zero;
  assign ev_hdr      = byte_ok && !is_zero && (state == ST_HDR);
  assign ev_data     = byte_ok && !is_zero && (state == ST_RUN);
  assign ev_overlong = ev_data && idx_full;
  assign ev_payload  = ev_data && !idx_full;

  cobs_rx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_err     (ev_err),
    .ev_delim   (ev_delim),
    .ev_hdr     (ev_hdr),
    .ev_overlong(ev_overlong),
    .state_o    (state)
  );

  cobs_rx_skip u_skip (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_hdr     (ev_hdr),
    .ev_payload (ev_payload),
    .byte_i     (in_byte),
    .out_valid_o(out_valid),
    .out_byte_o (out_byte),
    .zero_emit_o(zero_emit)
  );

  cobs_rx_index #(
    .MAX_PAYLOAD(MAX_PAYLOAD),
    .IDX_W      (IDX_W)
  ) u_index (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_err      (ev_err),
    .ev_delim    (ev_delim),
    .ev_payload  (ev_payload),
    .ev_overlong (ev_overlong),
    .full_o      (idx_full),
    .out_index_o (out_index),
    .frame_done_o(frame_done),
    .frame_len_o (frame_len)
  );

  cobs_rx_satcnt #(
    .CNT_W(CNT_W)
  ) u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (ev_err),
    .count_o(overrun_count)
  );

  // R2
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC && byte_ok && !is_zero) |=> (!out_valid && !frame_done));

  // R10
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && frame_done));

  // R9
  overlong_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overlong |=> (!out_valid && state == ST_SYNC));

  // R7
  ovr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_overrun |=> (!out_valid && !frame_done));

  // R6
  zero_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_emit |-> (ev_payload && state == ST_RUN));

endmodule

// File: tb/cobs_rx_decoder_test.sv
module cobs_rx_decoder_test;

  localparam int MAXP  = 6;
  localparam int CW    = 3;
  localparam int IW    = $clog2(MAXP + 1);
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic          in_overrun = 1'b0;
  logic          out_valid;
  logic [7:0]    out_byte;
  logic [IW-1:0] out_index;
  logic          frame_done;
  logic [IW-1:0] frame_len;
  logic [CW-1:0] overrun_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cobs_rx_decoder #(.MAX_PAYLOAD(MAXP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_overrun(in_overrun), .out_valid(out_valid), .out_byte(out_byte),
    .out_index(out_index), .frame_done(frame_done), .frame_len(frame_len),
    .overrun_count(overrun_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 = hunting for sync, 1 = expecting overhead, 2 = payload
  int m_st, m_skip, m_idx, m_cnt;
  int e_valid, e_byte, e_idx, e_done, e_len;

  always @(posedge clk) begin
    e_valid = 0;
    e_done  = 0;
    if (!rst_n) begin
      m_st = 0; m_skip = 0; m_idx = 0; m_cnt = 0;
    end else if (in_overrun) begin
      m_idx = 0; m_st = 0;
      if (m_cnt < CMAX) m_cnt = m_cnt + 1;
    end else if (in_valid) begin
      if (in_byte == 8'h00) begin
        e_done = 1; e_len = m_idx; m_idx = 0; m_st = 1;
      end else if (m_st == 1) begin
        m_skip = in_byte; m_st = 2;
      end else if (m_st == 2) begin
        if (m_idx >= MAXP) begin
          m_st = 0; m_idx = 0;
        end else begin
          m_skip = m_skip - 1;
          if (m_skip == 0) begin
            e_byte = 0; m_skip = in_byte;
          end else begin
            e_byte = in_byte;
          end
          e_valid = 1; e_idx = m_idx; m_idx = m_idx + 1;
        end
      end
    end
  end

  // Capture for directed frame checks plus per-cycle model comparison
  logic [7:0] got_q[$];
  int         got_len;
  int         done_n;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(out_valid == e_valid[0], "R5 out_valid vs model", out_valid, e_valid);
      if (e_valid != 0) begin
        check(out_byte == e_byte[7:0], "R6 out_byte vs model", out_byte, e_byte);
        check(out_index == e_idx[IW-1:0], "R10 out_index vs model", out_index, e_idx);
      end
      check(frame_done == e_done[0], "R3 frame_done vs model", frame_done, e_done);
      if (e_done != 0)
        check(frame_len == e_len[IW-1:0], "R3 frame_len vs model", frame_len, e_len);
      check(overrun_count == m_cnt[CW-1:0], "R8 overrun_count vs model", overrun_count, m_cnt);
      check(!(out_valid && frame_done), "R10 valid/done exclusive", out_valid, 0);
      if (out_valid) got_q.push_back(out_byte);
      if (frame_done) begin got_len = int'(frame_len); done_n++; end
    end
  end

  task automatic clear_cap();
    got_q.delete(); got_len = -1; done_n = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit ovr);
    @(posedge clk); #1;
    in_valid = 1'b1; in_byte = b; in_overrun = ovr;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0; in_overrun = 1'b0; in_byte = 8'h00;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_seq(input logic [7:0] s[$]);
    foreach (s[i]) send(s[i], 1'b0);
    idle(2);
  endtask

  task automatic expect_frame(input string req, input logic [7:0] exp[$], input int exp_len);
    check(got_q.size() == exp.size(), {req, " decoded count"}, got_q.size(), exp.size());
    foreach (exp[i])
      if (i < got_q.size())
        check(got_q[i] == exp[i], {req, " decoded byte"}, got_q[i], exp[i]);
    check(done_n == 1, {req, " one frame_done"}, done_n, 1);
    check(got_len == exp_len, {req, " frame_len"}, got_len, exp_len);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_cap();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(frame_done == 1'b0, "R1 frame_done after reset", frame_done, 0);
    check(overrun_count == '0, "R1 overrun_count after reset", overrun_count, 0);

    // R2: non-zero bytes before any delimiter are dropped
    clear_cap();
    send_seq('{8'h11, 8'h22, 8'h03, 8'h44});
    check(got_q.size() == 0, "R2 no output in sync search", got_q.size(), 0);
    check(done_n == 0, "R2 no frame_done in sync search", done_n, 0);

    // R3: delimiter from sync search closes an empty frame
    clear_cap();
    send_seq('{8'h00});
    check(done_n == 1 && got_len == 0, "R3 empty frame on first delimiter", got_len, 0);

    // R4 R5 R6: overhead byte hidden, pass-through and hidden zero
    clear_cap();
    send_seq('{8'h03, 8'h11, 8'h22, 8'h02, 8'h33, 8'h00});
    expect_frame("R6 mixed frame", '{8'h11, 8'h22, 8'h00, 8'h33}, 4);

    clear_cap();
    send_seq('{8'h01, 8'h01, 8'h00});
    expect_frame("R6 single zero", '{8'h00}, 1);

    clear_cap();
    send_seq('{8'h02, 8'h11, 8'h01, 8'h01, 8'h01, 8'h00});
    expect_frame("R6 trailing zeros", '{8'h11, 8'h00, 8'h00, 8'h00}, 4);

    clear_cap();
    send_seq('{8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00});
    expect_frame("R5 no zeros", '{8'h11, 8'h22, 8'h33, 8'h44}, 4);

    clear_cap();
    send_seq('{8'h01, 8'h00});
    expect_frame("R4 overhead only", '{}, 0);

    // R7: overrun mid frame, then stale byte ignored until delimiter
    clear_cap();
    send(8'h04, 1'b0); send(8'hAA, 1'b0); send(8'hBB, 1'b0);
    send(8'h00, 1'b1);       // overrun beats a delimiter in the same cycle
    send(8'hCC, 1'b0);
    idle(2);
    check(got_q.size() == 2, "R7 bytes before overrun", got_q.size(), 2);
    check(done_n == 0, "R7 overrun suppresses delimiter", done_n, 0);
    clear_cap();
    send_seq('{8'h00, 8'h02, 8'h55, 8'h00});
    check(done_n == 2, "R7 resync frames", done_n, 2);
    check(got_len == 1, "R7 resync frame_len", got_len, 1);
    check(got_q.size() == 1 && got_q[0] == 8'h55, "R7 resync data", got_q.size(), 1);

    // R9: exact limit frame, then one byte too many
    clear_cap();
    send_seq('{8'h07, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h00});
    expect_frame("R9 full frame", '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, 6);
    clear_cap();
    send_seq('{8'h09, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h00});
    check(got_q.size() == 6, "R9 overlong output count", got_q.size(), 6);
    check(got_len == 0, "R9 overlong then empty close", got_len, 0);

    // R8: saturation of overrun count
    for (int i = 0; i < CMAX + 3; i++) send(8'h00, 1'b1);
    idle(2);
    check(overrun_count == CW'(CMAX), "R8 saturated count", overrun_count, CMAX);

    // Random stream checked against the model every cycle (R3 R5 R6 R7 R9 R10)
    void'($urandom(7));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      @(posedge clk); #1;
      in_overrun = (r < 2);
      if (r < 14) begin
        in_valid = 1'b1; in_byte = 8'h00;
      end else if (r < 88) begin
        in_valid = 1'b1;
        in_byte = (r < 60) ? 8'(1 + ($urandom % 4)) : 8'(1 + ($urandom % 255));
      end else begin
        in_valid = 1'b0;
      end
    end
    idle(3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule